// File: doc/BRIEF.md
# Receive Frame Buffer with Commit and Rollback

This block holds received CAN frames in a circular memory of 32-bit words and hands them to host logic one word at a time. The receiver opens a frame with a one-cycle start pulse and then writes the header fields on a metadata strobe. Payload words follow, one per data strobe. The frame ends with either a commit pulse or an abort pulse. Until the commit arrives, every word of the frame sits beyond the committed write pointer. The reader cannot see these words, and they do not reduce the free space that is reported. An abort simply throws them away.

Each frame also carries a 64-bit timestamp. A mode input chooses when it is taken: at the frame start, or in the commit cycle. If space runs out in the middle of a frame, that frame is dropped and a sticky overrun flag is raised. Only an explicit clear pulse lowers the flag. While it stays set, later frames are refused.

The reader sees the word at the read pointer on `rd_word` and steps forward with `rd_next`. Status outputs give the empty flag, the number of complete frames, the free word count and both pointer positions.

Top module: `rx_frame_store`

## Requirements
- R1: After reset, `empty`=1, `frame_cnt`=0, `free_words`=DEPTH, `rd_ptr`=0, `wr_ptr`=0 and `overrun`=0.
- R2: A committed frame is read back in this order: format word, identifier word, timestamp low, timestamp high, then the payload words in strobe order. The format word holds DLC in [3:0], RTR in bit 4, extended identifier in bit 5, FD in bit 6, BRS in bit 7, ESI in bit 8, and the total word count (4 + payload words) in [20:16]; all other bits are 0. The identifier word holds the identifier in [28:0] and zeros above it. The payload word count is 0 for RTR. For classic frames it is ceil(min(DLC,8)/4). For FD frames it is ceil(DLC/4) for DLC up to 8, DLC-6 for DLC 9 to 12, and 4*(DLC-11) for DLC 13 to 15.
- R3: With `ts_at_end`=0, the stored timestamp is the value of `ts_now` in the cycle of the frame-start pulse. With `ts_at_end`=1, it is the value in the commit cycle. The mode is held steady while a frame is being written.
- R4: Before the commit, a frame being written changes none of `empty`, `free_words`, `frame_cnt` or `wr_ptr`. A commit that follows the metadata strobe, with `overrun` low, adds the whole frame in one step: on the next cycle `frame_cnt` goes up by 1, and `free_words` falls by the frame's word count while `wr_ptr` advances by that same count.
- R5: The following all discard the partial frame and leave committed frames untouched: an abort at any point after the start, a second start pulse, or a commit that arrives before the metadata strobe. An abort in the same cycle as another strobe takes precedence.
- R6: The frame is dropped and `overrun` rises if either of two things happens. One is a metadata strobe arriving when fewer than 4 words are free. The other is a data strobe arriving when the words already stored plus the frame's pending words fill the memory. After that, the rest of the frame's strobes and its commit have no effect.
- R7: `overrun` stays set until a one-cycle `ovr_clear` pulse arrives; an abort does not clear it. While it is set, a metadata strobe drops the frame.
- R8: `rd_word` shows the word at `rd_ptr`. A `rd_next` pulse on a non-empty buffer advances `rd_ptr` by one, wrapping modulo DEPTH, and raises `free_words` by one. On an empty buffer, the pulse changes nothing.
- R9: `frame_cnt` falls by one in the cycle after the last word of a frame is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse opening a frame |
| meta_we | input | 1 | Metadata strobe |
| meta_id | input | 29 | Identifier |
| meta_dlc | input | 4 | Data length code |
| meta_rtr | input | 1 | Remote request flag |
| meta_ext | input | 1 | Extended identifier flag |
| meta_fd | input | 1 | FD frame flag |
| meta_brs | input | 1 | Bit-rate switch flag |
| meta_esi | input | 1 | Error state flag |
| word_we | input | 1 | Payload word strobe |
| word_data | input | 32 | Payload word, first byte in [7:0] |
| frame_abort | input | 1 | Discards the open frame |
| frame_commit | input | 1 | Makes the open frame readable |
| ts_at_end | input | 1 | Timestamp at commit (1) or at start (0) |
| ts_now | input | 64 | Running timestamp |
| ovr_clear | input | 1 | Clears the overrun flag |
| rd_next | input | 1 | Advances the read pointer |
| rd_word | output | 32 | Word at the read pointer |
| empty | output | 1 | No committed word left |
| frame_cnt | output | AW+1 | Committed frames not yet fully read |
| free_words | output | AW+1 | Words not held by committed frames |
| rd_ptr | output | AW | Read pointer |
| wr_ptr | output | AW | Committed write pointer |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A speculative pointer that is not restored after an abort shows up in two places. The next committed frame lands at the wrong offset, and `wr_ptr` is wrong one cycle after that frame's commit. A fault in the free-space arithmetic behaves differently: `free_words` disagrees in the cycle after the faulty commit or read. A misplaced overrun decision shows up when the frame is committed, as a frame that is kept or lost wrongly. A read-side frame counter that has lost its place in the frame makes `frame_cnt` drift at the end of the next frame it reads out.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

  localparam int WC_W      = 5;
  localparam int HDR_WORDS = 4;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_OPEN,
    FS_META,
    FS_DROP
  } fstate_e;

  typedef struct packed {
    logic [3:0] dlc;
    logic       rtr;
    logic       ext;
    logic       fd;
    logic       brs;
    logic       esi;
  } meta_t;

  // payload byte count from the length code, then rounded up to words
  function automatic logic [WC_W-1:0] payload_words(input meta_t m);
    logic [6:0] nbytes;
    logic [6:0] nwords;
    if (m.rtr)                     nbytes = 7'd0;
    else if (!m.fd && m.dlc > 4'd8) nbytes = 7'd8;
    else begin
      case (m.dlc)
        4'd9:    nbytes = 7'd12;
        4'd10:   nbytes = 7'd16;
        4'd11:   nbytes = 7'd20;
        4'd12:   nbytes = 7'd24;
        4'd13:   nbytes = 7'd32;
        4'd14:   nbytes = 7'd48;
        4'd15:   nbytes = 7'd64;
        default: nbytes = {3'd0, m.dlc};
      endcase
    end
    nwords = (nbytes + 7'd3) >> 2;
    return nwords[WC_W-1:0];
  endfunction

  function automatic logic [31:0] format_word(input meta_t m);
    logic [WC_W-1:0] total;
    total = payload_words(m) + WC_W'(HDR_WORDS);
    return {11'd0, total, 7'd0, m.esi, m.brs, m.fd, m.ext, m.rtr, m.dlc};
  endfunction

  function automatic logic [WC_W-1:0] words_in_format(input logic [31:0] w);
    return w[20:16];
  endfunction

endpackage

// File: rtl/rxfb_mem.sv
module rxfb_mem #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  input  logic [31:0]   a_data,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  input  logic [31:0]   b_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (b_en && b_addr == AW'(i))      mem[i] <= b_data;
      else if (a_en && a_addr == AW'(i)) mem[i] <= a_data;
    end
  end

  assign rd_data = mem[rd_addr];

  // R2
  port_clash_chk: assert property (@(posedge clk)
    !(a_en && b_en && a_addr == b_addr));

endmodule

// File: rtl/rxfb_writer.sv
module rxfb_writer
  import rxfb_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          meta_we,
  input  logic [28:0]   meta_id,
  input  meta_t         meta,
  input  logic          word_we,
  input  logic [31:0]   word_data,
  input  logic          frame_abort,
  input  logic          frame_commit,
  input  logic          ts_at_end,
  input  logic [63:0]   ts_now,
  input  logic          ovr_clear,
  input  logic [AW:0]   used,
  output logic          a_en,
  output logic [AW-1:0] a_addr,
  output logic [31:0]   a_data,
  output logic          b_en,
  output logic [AW-1:0] b_addr,
  output logic [31:0]   b_data,
  output logic          commit_fire,
  output logic [AW:0]   commit_words,
  output logic [AW-1:0] wr_ptr,
  output logic          overrun
);
  localparam int DEPTH = 1 << AW;
  localparam int UW    = AW + 1;

  fstate_e       state;
  logic [AW-1:0] spec_ptr, commit_ptr;
  logic [UW-1:0] spec_cnt;
  logic [63:0]   ts_hold;
  logic          ovr_q;

  logic [UW-1:0] room;
  logic          go_abort, go_start, go_commit, go_meta, go_data;
  logic          meta_ok, data_ok, ovr_evt;
  logic [63:0]   ts_sel;

  assign room      = UW'(DEPTH) - used - spec_cnt;
  assign go_abort  = frame_abort;
  assign go_start  = !frame_abort && frame_start;
  assign go_commit = !frame_abort && !frame_start && frame_commit;
  assign go_meta   = !frame_abort && !frame_start && !frame_commit &&
                     meta_we && state == FS_OPEN;
  assign go_data   = !frame_abort && !frame_start && !frame_commit &&
                     word_we && state == FS_META;

  assign commit_fire = go_commit && state == FS_META && !ovr_q;
  assign meta_ok     = go_meta && !ovr_q && room >= UW'(HDR_WORDS);
  assign data_ok     = go_data && room != '0;
  assign ovr_evt     = (go_meta && !ovr_q && room < UW'(HDR_WORDS)) ||
                       (go_data && room == '0);

  assign ts_sel = ts_at_end ? ts_now : ts_hold;

  assign a_en   = meta_ok || data_ok || commit_fire;
  assign a_addr = commit_fire ? commit_ptr + AW'(2) : spec_ptr;
  assign a_data = commit_fire ? ts_sel[31:0] :
                  meta_ok     ? format_word(meta) : word_data;
  assign b_en   = meta_ok || commit_fire;
  assign b_addr = commit_fire ? commit_ptr + AW'(3) : spec_ptr + AW'(1);
  assign b_data = commit_fire ? ts_sel[63:32] : {3'd0, meta_id};

  assign commit_words = spec_cnt;
  assign wr_ptr       = commit_ptr;
  assign overrun      = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= FS_IDLE;
      spec_ptr   <= '0;
      commit_ptr <= '0;
      spec_cnt   <= '0;
      ts_hold    <= '0;
      ovr_q      <= 1'b0;
    end else begin
      if (ovr_evt)        ovr_q <= 1'b1;
      else if (ovr_clear) ovr_q <= 1'b0;

      if (go_abort) begin
        state    <= FS_IDLE;
        spec_ptr <= commit_ptr;
        spec_cnt <= '0;
      end else if (go_start) begin
        state    <= FS_OPEN;
        spec_ptr <= commit_ptr;
        spec_cnt <= '0;
        if (!ts_at_end) ts_hold <= ts_now;
      end else if (go_commit) begin
        state    <= FS_IDLE;
        spec_cnt <= '0;
        if (commit_fire) commit_ptr <= spec_ptr;
        else             spec_ptr   <= commit_ptr;
      end else if (go_meta) begin
        if (meta_ok) begin
          state    <= FS_META;
          spec_ptr <= spec_ptr + AW'(HDR_WORDS);
          spec_cnt <= UW'(HDR_WORDS);
        end else begin
          state    <= FS_DROP;
          spec_ptr <= commit_ptr;
          spec_cnt <= '0;
        end
      end else if (go_data) begin
        if (data_ok) begin
          spec_ptr <= spec_ptr + AW'(1);
          spec_cnt <= spec_cnt + UW'(1);
        end else begin
          state    <= FS_DROP;
          spec_ptr <= commit_ptr;
          spec_cnt <= '0;
        end
      end
    end
  end

  // R4
  commit_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(commit_ptr));

  // R5
  abort_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> (spec_ptr == commit_ptr && spec_cnt == '0));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !ovr_clear |=> ovr_q);

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clear && !ovr_evt |=> !ovr_q);

endmodule

// File: rtl/rxfb_reader.sv
module rxfb_reader
  import rxfb_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_next,
  input  logic            empty,
  input  logic [WC_W-1:0] head_wc,
  output logic [AW-1:0]   rd_ptr,
  output logic            rd_take,
  output logic            frame_done
);
  logic [WC_W-1:0] left;

  assign rd_take    = rd_next && !empty;
  assign frame_done = rd_take && left == WC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      left   <= '0;
    end else if (rd_take) begin
      rd_ptr <= rd_ptr + AW'(1);
      left   <= (left == '0) ? head_wc - WC_W'(1) : left - WC_W'(1);
    end
  end

  // R8
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next && empty |=> $stable(rd_ptr));

endmodule

// File: rtl/rx_frame_store.sv
module rx_frame_store
  import rxfb_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          meta_we,
  input  logic [28:0]   meta_id,
  input  logic [3:0]    meta_dlc,
  input  logic          meta_rtr,
  input  logic          meta_ext,
  input  logic          meta_fd,
  input  logic          meta_brs,
  input  logic          meta_esi,
  input  logic          word_we,
  input  logic [31:0]   word_data,
  input  logic          frame_abort,
  input  logic          frame_commit,
  input  logic          ts_at_end,
  input  logic [63:0]   ts_now,
  input  logic          ovr_clear,
  input  logic          rd_next,
  output logic [31:0]   rd_word,
  output logic          empty,
  output logic [AW:0]   frame_cnt,
  output logic [AW:0]   free_words,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic          overrun
);
  localparam int DEPTH = 1 << AW;
  localparam int UW    = AW + 1;

  meta_t         meta;
  logic          a_en, b_en;
  logic [AW-1:0] a_addr, b_addr;
  logic [31:0]   a_data, b_data;
  logic          commit_fire, rd_take, frame_done;
  logic [UW-1:0] commit_words;
  logic [UW-1:0] used;

  assign meta = '{dlc: meta_dlc, rtr: meta_rtr, ext: meta_ext,
                  fd: meta_fd, brs: meta_brs, esi: meta_esi};

  rxfb_writer #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .meta_we(meta_we),
    .meta_id(meta_id), .meta(meta), .word_we(word_we), .word_data(word_data),
    .frame_abort(frame_abort), .frame_commit(frame_commit),
    .ts_at_end(ts_at_end), .ts_now(ts_now), .ovr_clear(ovr_clear),
    .used(used), .a_en(a_en), .a_addr(a_addr), .a_data(a_data),
    .b_en(b_en), .b_addr(b_addr), .b_data(b_data),
    .commit_fire(commit_fire), .commit_words(commit_words),
    .wr_ptr(wr_ptr), .overrun(overrun)
  );

  rxfb_mem #(.AW(AW)) u_mem (
    .clk(clk), .a_en(a_en), .a_addr(a_addr), .a_data(a_data),
    .b_en(b_en), .b_addr(b_addr), .b_data(b_data),
    .rd_addr(rd_ptr), .rd_data(rd_word)
  );

  rxfb_reader #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_next(rd_next), .empty(empty),
    .head_wc(words_in_format(rd_word)), .rd_ptr(rd_ptr),
    .rd_take(rd_take), .frame_done(frame_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used      <= '0;
      frame_cnt <= '0;
    end else begin
      used      <= used + (commit_fire ? commit_words : '0) - UW'(rd_take);
      frame_cnt <= frame_cnt + UW'(commit_fire) - UW'(frame_done);
    end
  end

  assign empty      = used == '0;
  assign free_words = UW'(DEPTH) - used;

  // R8
  used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= UW'(DEPTH));

  // R9
  empty_no_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> frame_cnt == '0);

  // R4
  commit_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire && !rd_take |=>
      free_words == $past(free_words) - $past(commit_words));

endmodule

// File: tb/sim_rx_frame_store.sv
`timescale 1ns/1ps
module sim_rx_frame_store;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_start = 0, b_meta = 0, b_word = 0, b_abort = 0, b_commit = 0;
  logic        b_tend = 0, b_clr = 0, b_rd = 0;
  logic [28:0] b_id = '0;
  logic [3:0]  b_dlc = '0;
  logic        b_rtr = 0, b_ext = 0, b_fd = 0, b_brs = 0, b_esi = 0;
  logic [31:0] b_wdata = '0;
  logic [63:0] ts_now = 64'h0123_4567_89AB_0000;

  logic [31:0]   rd_word;
  logic          empty, overrun;
  logic [AW:0]   frame_cnt, free_words;
  logic [AW-1:0] rd_ptr, wr_ptr;

  rx_frame_store #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(b_start), .meta_we(b_meta),
    .meta_id(b_id), .meta_dlc(b_dlc), .meta_rtr(b_rtr), .meta_ext(b_ext),
    .meta_fd(b_fd), .meta_brs(b_brs), .meta_esi(b_esi), .word_we(b_word),
    .word_data(b_wdata), .frame_abort(b_abort), .frame_commit(b_commit),
    .ts_at_end(b_tend), .ts_now(ts_now), .ovr_clear(b_clr), .rd_next(b_rd),
    .rd_word(rd_word), .empty(empty), .frame_cnt(frame_cnt),
    .free_words(free_words), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .overrun(overrun)
  );

  always #10 clk = ~clk;
  always @(negedge clk) ts_now = ts_now + 64'd1;

  int nchk = 0, nfail = 0;
  bit mon_on = 0, done = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int bwords(input logic [3:0] dlc, input logic fd,
                                input logic rtr);
    int d;
    if (rtr) return 0;
    if (!fd || dlc <= 8) begin
      d = (dlc > 8) ? 8 : int'(dlc);
      return (d + 3) / 4;
    end
    if (dlc <= 12) return int'(dlc) - 6;
    return 4 * (int'(dlc) - 11);
  endfunction

  // ---------------- reference model ----------------
  logic [31:0] mq[$];
  logic [31:0] spq[$];
  int          m_frames = 0, m_wptr = 0, m_rptr = 0, m_left = 0, m_st = 0;
  bit          m_ovr = 0;
  logic [63:0] m_ts = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); spq.delete();
      m_frames = 0; m_wptr = 0; m_rptr = 0; m_left = 0; m_st = 0;
      m_ovr = 0; m_ts = '0;
    end else begin
      int   used0;
      bit   evt;
      logic [31:0] w;
      used0 = mq.size();
      evt   = 0;
      if (b_rd && mq.size() > 0) begin
        w = mq.pop_front();
        m_rptr = (m_rptr + 1) % DEPTH;
        if (m_left == 0) m_left = int'(w[20:16]) - 1;
        else begin
          m_left--;
          if (m_left == 0) m_frames--;
        end
      end
      if (b_abort) begin
        m_st = 0; spq.delete();
      end else if (b_start) begin
        m_st = 1; spq.delete();
        if (!b_tend) m_ts = ts_now;
      end else if (b_commit) begin
        if (m_st == 2 && !m_ovr) begin
          spq[2] = b_tend ? ts_now[31:0]  : m_ts[31:0];
          spq[3] = b_tend ? ts_now[63:32] : m_ts[63:32];
          foreach (spq[i]) mq.push_back(spq[i]);
          m_frames++;
          m_wptr = (m_wptr + spq.size()) % DEPTH;
        end
        m_st = 0; spq.delete();
      end else if (b_meta && m_st == 1) begin
        if (m_ovr) m_st = 3;
        else if (DEPTH - used0 < 4) begin evt = 1; m_st = 3; end
        else begin
          spq.push_back((32'(4 + bwords(b_dlc, b_fd, b_rtr)) << 16) |
                        (32'(b_esi) << 8) | (32'(b_brs) << 7) |
                        (32'(b_fd) << 6) | (32'(b_ext) << 5) |
                        (32'(b_rtr) << 4) | 32'(b_dlc));
          spq.push_back(32'(b_id));
          spq.push_back(32'd0);
          spq.push_back(32'd0);
          m_st = 2;
        end
      end else if (b_word && m_st == 2) begin
        if (DEPTH - used0 - spq.size() < 1) begin
          evt = 1; m_st = 3; spq.delete();
        end else spq.push_back(b_wdata);
      end
      if (evt) m_ovr = 1;
      else if (b_clr) m_ovr = 0;
    end
  end

  // per-cycle comparison, outputs depend only on registers
  always @(negedge clk) begin
    if (mon_on) begin
      chk(empty == (mq.size() == 0), "R8 empty", 64'(empty), 64'(mq.size() == 0));
      chk(free_words == (AW+1)'(DEPTH - mq.size()), "R4,R8 free_words",
          64'(free_words), 64'(DEPTH - mq.size()));
      chk(frame_cnt == (AW+1)'(m_frames), "R9 frame_cnt",
          64'(frame_cnt), 64'(m_frames));
      chk(wr_ptr == AW'(m_wptr), "R4,R5 wr_ptr", 64'(wr_ptr), 64'(m_wptr));
      chk(rd_ptr == AW'(m_rptr), "R8 rd_ptr", 64'(rd_ptr), 64'(m_rptr));
      chk(overrun == m_ovr, "R6,R7 overrun", 64'(overrun), 64'(m_ovr));
      if (mq.size() > 0)
        chk(rd_word == mq[0], "R2,R3 rd_word", 64'(rd_word), 64'(mq[0]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic run_frame(input logic [3:0] dlc, input logic fd, input logic rtr,
                           input logic tend, input int abort_at);
    int nw;
    logic [AW:0] free0;
    nw = bwords(dlc, fd, rtr);
    b_tend = tend;
    free0 = free_words;
    pulse(b_start);
    if (abort_at == 0) begin pulse(b_abort); return; end
    repeat (2) @(negedge clk);
    b_dlc = dlc; b_fd = fd; b_rtr = rtr; b_ext = dlc[0];
    b_brs = fd & dlc[1]; b_esi = dlc[2]; b_id = {dlc, 25'h1A5_5C3} ^ 29'(ts_now);
    pulse(b_meta);
    for (int i = 0; i < nw; i++) begin
      b_wdata = 32'hC0DE_0000 ^ 32'(ts_now) ^ (32'(i) << 24);
      pulse(b_word);
      if (abort_at == i + 1) begin pulse(b_abort); return; end
    end
    chk(free_words == free0, "R4 free before commit", 64'(free_words), 64'(free0));
    pulse(b_commit);
    @(negedge clk);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) pulse(b_rd);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty == 1'b1, "R1 empty", 64'(empty), 64'd1);
    chk(frame_cnt == '0, "R1 frame_cnt", 64'(frame_cnt), 64'd0);
    chk(free_words == (AW+1)'(DEPTH), "R1 free_words", 64'(free_words), 64'(DEPTH));
    chk(rd_ptr == '0 && wr_ptr == '0, "R1 pointers", 64'({rd_ptr, wr_ptr}), 64'd0);
    chk(overrun == 1'b0, "R1 overrun", 64'(overrun), 64'd0);
    mon_on = 1;

    run_frame(4'd8, 0, 0, 0, -1);               // 6 words
    chk(frame_cnt == 1, "R4 count after commit", 64'(frame_cnt), 64'd1);
    chk(free_words == 26, "R4 free after commit", 64'(free_words), 64'd26);

    run_frame(4'd5, 0, 0, 0, 0);                // abort before metadata
    run_frame(4'd8, 1, 0, 1, 2);                // abort after two words
    chk(free_words == 26 && wr_ptr == 6, "R5 abort keeps state",
        64'({free_words, wr_ptr}), 64'({6'd26, 5'd6}));

    pulse(b_start); pulse(b_meta); pulse(b_word);
    run_frame(4'd13, 1, 0, 1, -1);              // restart, 12 words
    chk(free_words == 14 && frame_cnt == 2, "R5 restart",
        64'({free_words, frame_cnt}), 64'({6'd14, 6'd2}));

    pulse(b_start); pulse(b_commit); pulse(b_meta); pulse(b_commit);
    chk(free_words == 14, "R5 early commit dropped", 64'(free_words), 64'd14);

    run_frame(4'd3, 0, 1, 0, -1);               // RTR, 4 words
    run_frame(4'd15, 1, 0, 1, -1);              // 20 words, does not fit
    chk(overrun == 1'b1, "R6 overrun on data", 64'(overrun), 64'd1);
    chk(free_words == 10 && frame_cnt == 3, "R6 frame dropped",
        64'({free_words, frame_cnt}), 64'({6'd10, 6'd3}));

    run_frame(4'd1, 0, 0, 0, -1);               // refused while flag set
    chk(free_words == 10, "R7 refused while set", 64'(free_words), 64'd10);
    pulse(b_abort);
    chk(overrun == 1'b1, "R7 abort keeps flag", 64'(overrun), 64'd1);
    pulse(b_clr);
    chk(overrun == 1'b0, "R7 clear", 64'(overrun), 64'd0);

    run_frame(4'd2, 0, 0, 1, -1);               // 5 words
    chk(free_words == 5 && frame_cnt == 4, "R4 fifth frame",
        64'({free_words, frame_cnt}), 64'({6'd5, 6'd4}));

    read_n(6);
    chk(frame_cnt == 3, "R9 one frame read", 64'(frame_cnt), 64'd3);
    read_n(21);
    chk(empty == 1'b1 && frame_cnt == 0, "R9 all read",
        64'({empty, frame_cnt}), 64'd1 << 6);
    begin
      logic [AW-1:0] rp;
      rp = rd_ptr;
      read_n(3);
      chk(rd_ptr == rp && free_words == (AW+1)'(DEPTH), "R8 empty read",
          64'(rd_ptr), 64'(rp));
    end

    for (int k = 0; k < 6; k++) begin           // wrap the pointers
      run_frame(4'd8, 0, 0, k[0], -1);
      read_n(6);
    end
    chk(empty == 1'b1 && wr_ptr == rd_ptr, "R8 wrap", 64'(wr_ptr), 64'(rd_ptr));

    for (int k = 0; k < 5; k++) run_frame(4'(7 + k % 2), 0, 0, k[1], -1);
    run_frame(4'd0, 0, 0, 0, -1);               // metadata with 2 free
    chk(overrun == 1'b1, "R6 overrun on metadata", 64'(overrun), 64'd1);
    chk(frame_cnt == 5, "R6 count kept", 64'(frame_cnt), 64'd5);
    pulse(b_clr);
    read_n(30);
    chk(empty == 1'b1 && frame_cnt == 0, "R9 drained", 64'(frame_cnt), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R1..all act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule